// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is a bank of configurable output cells for a sum-of-products logic fabric. Each cell takes one sum term from the product array, a pin input and an output-enable request. It produces a pin value, a pin driver enable and a feedback bit that returns to the array. Each cell can pass its sum straight through, store it in a D or T flip-flop, hold it in a level-sensitive latch, or capture the pin itself as a synchronizing input register. Every cell also has its own output inversion, its own choice of one of the macro clocks, and a buried flag that frees its pin for use as an input.

All logic runs on one system clock. The macro clocks arrive as level signals and are sampled on every system clock edge. A rising edge of a macro clock is seen in the cycle where it is sampled high after having been sampled low. A latch is open in each cycle where its clock is sampled high. The configuration is static: it is copied from the configuration inputs while reset is high and held once reset is released.

Top module: `mc_bank`

## Requirements
- R1: In pass-through mode (mode code 2'b00), pin_out and fb_out of the cell equal its sum_in XOR its invert bit in the same cycle, with no dependence on any macro clock.
- R2: When the invert bit is 1 in register or latch mode, pin_out and fb_out are the complement of the stored bit. When it is 0, they equal the stored bit.
- R3: In register mode (mode code 2'b01) with type bit 0 (D), a rising edge of the selected macro clock loads sum_in into the stored bit. The new value shows on the outputs in the following system cycle.
- R4: In register mode with type bit 1 (T), a rising edge of the selected macro clock inverts the stored bit when sum_in is 1 and leaves it unchanged when sum_in is 0.
- R5: In latch mode (mode code 2'b10), the stored bit takes sum_in at every system edge where the selected macro clock is sampled high, and it holds while that clock is sampled low.
- R6: The 2-bit clock select of a cell (value k picks mclk[k]) decides which macro clock drives it. Edges on the other macro clocks leave the stored bit unchanged.
- R7: In input-register mode (mode code 2'b11), a rising edge of the selected macro clock captures pin_in. fb_out carries the captured bit without inversion.
- R8: pin_oe equals oe_in unless the cell is buried (buried bit 1) or in input-register mode, in which case pin_oe is 0.
- R9: A synchronous active-high reset clears every stored bit to 0. A macro clock that is already high when reset is released does not count as a rising edge.
- R10: The configuration inputs are captured on every system edge while reset is high. Changes to them while reset is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset and configuration load |
| mclk | input | NUM_CLK | Macro clock levels, sampled on clk |
| sum_in | input | N_CELL | Sum term per cell from the product array |
| pin_in | input | N_CELL | Pin level per cell |
| oe_in | input | N_CELL | Output-enable request per cell |
| cfg_mode | input | 2*N_CELL | Mode code per cell (2 bits each) |
| cfg_tff | input | N_CELL | Register type per cell, 1 = T |
| cfg_inv | input | N_CELL | Output inversion per cell, 1 = invert |
| cfg_csel | input | SEL_W*N_CELL | Macro clock index per cell |
| cfg_buried | input | N_CELL | Buried flag per cell, 1 = pin driver off |
| pin_out | output | N_CELL | Value to the pin driver |
| pin_oe | output | N_CELL | Pin driver enable |
| fb_out | output | N_CELL | Feedback bit to the product array |

## Verification
The case where two functions meet in one cycle is a reset release that coincides with a macro clock already high. The clock history is cleared in the same edge that loads the configuration, so that clock must not count as a rising edge in the first free cycle. The bench holds every macro clock high through the last reset cycle and the first cycle after it, while the stored bits are still 0. It then expects the outputs to stay at their reset values until each clock has been seen low and then high again. Independent toggling of unselected clocks in the same cycles as selected edges checks that each cell takes only its own clock.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MD_COMB  = 2'b00,
    MD_REG   = 2'b01,
    MD_LATCH = 2'b10,
    MD_INREG = 2'b11
  } mc_mode_e;

  typedef struct packed {
    mc_mode_e mode;
    logic     tff;
    logic     inv;
    logic     buried;
  } mc_cfg_t;

endpackage

// File: rtl/mc_clk_track.sv
module mc_clk_track #(
  parameter int NUM_CLK = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CLK-1:0] mclk,
  output logic [NUM_CLK-1:0] mclk_lvl,
  output logic [NUM_CLK-1:0] mclk_rise
);

  logic [NUM_CLK-1:0] prev_q;

  // History starts all-high so a clock held high over reset is no edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= mclk;
  end

  assign mclk_lvl  = mclk;
  assign mclk_rise = mclk & ~prev_q;

  assert_no_edge_at_release_R9: assert property (
    @(posedge clk) disable iff (rst) $fell(rst) |-> (mclk_rise == '0));

endmodule

// File: rtl/mc_cfg_hold.sv
module mc_cfg_hold
  import mc_pkg::*;
#(
  parameter int N_CELL = 4,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [2*N_CELL-1:0]           cfg_mode,
  input  logic [N_CELL-1:0]             cfg_tff,
  input  logic [N_CELL-1:0]             cfg_inv,
  input  logic [SEL_W*N_CELL-1:0]       cfg_csel,
  input  logic [N_CELL-1:0]             cfg_buried,
  output mc_cfg_t [N_CELL-1:0]          cfg_q,
  output logic [N_CELL-1:0][SEL_W-1:0]  csel_q
);

  mc_cfg_t [N_CELL-1:0]         cfg_d;
  logic [N_CELL-1:0][SEL_W-1:0] csel_d;

  for (genvar i = 0; i < N_CELL; i++) begin : g_pack
    always_comb begin
      cfg_d[i].mode   = mc_mode_e'(cfg_mode[2*i +: 2]);
      cfg_d[i].tff    = cfg_tff[i];
      cfg_d[i].inv    = cfg_inv[i];
      cfg_d[i].buried = cfg_buried[i];
      csel_d[i]       = cfg_csel[SEL_W*i +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= cfg_d;
      csel_q <= csel_d;
    end
  end

  assert_cfg_frozen_R10: assert property (
    @(posedge clk) disable iff (rst) !rst |=> ($stable(cfg_q) && $stable(csel_q)));

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  mc_cfg_t            cfg,
  input  logic [SEL_W-1:0]   csel,
  input  logic [NUM_CLK-1:0] clk_lvl,
  input  logic [NUM_CLK-1:0] clk_rise,
  input  logic               sum,
  input  logic               pin_in,
  input  logic               oe_req,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               fb
);

  logic q;
  logic sel_rise;
  logic sel_lvl;

  assign sel_rise = clk_rise[csel];
  assign sel_lvl  = clk_lvl[csel];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      unique case (cfg.mode)
        MD_REG:   if (sel_rise) q <= cfg.tff ? (q ^ sum) : sum;
        MD_LATCH: if (sel_lvl)  q <= sum;
        MD_INREG: if (sel_rise) q <= pin_in;
        default:  q <= q;
      endcase
    end
  end

  always_comb begin
    if (cfg.mode == MD_COMB) begin
      pin_out = sum ^ cfg.inv;
      fb      = sum ^ cfg.inv;
    end else if (cfg.mode == MD_INREG) begin
      pin_out = q ^ cfg.inv;
      fb      = q;
    end else begin
      pin_out = q ^ cfg.inv;
      fb      = q ^ cfg.inv;
    end
    pin_oe = oe_req & ~cfg.buried & (cfg.mode != MD_INREG);
  end

  assert_d_load_R3: assert property (
    @(posedge clk) disable iff (rst)
    (cfg.mode == MD_REG && !cfg.tff && sel_rise) |=> (q == $past(sum)));

  assert_t_toggle_R4: assert property (
    @(posedge clk) disable iff (rst)
    (cfg.mode == MD_REG && cfg.tff && sel_rise && sum) |=> (q != $past(q)));

  assert_latch_hold_R5: assert property (
    @(posedge clk) disable iff (rst)
    (cfg.mode == MD_LATCH && !sel_lvl) |=> $stable(q));

  assert_no_edge_hold_R6: assert property (
    @(posedge clk) disable iff (rst)
    ((cfg.mode == MD_REG || cfg.mode == MD_INREG) && !sel_rise) |=> $stable(q));

  assert_pin_capture_R7: assert property (
    @(posedge clk) disable iff (rst)
    (cfg.mode == MD_INREG && sel_rise) |=> (fb == $past(pin_in)));

  assert_driver_off_R8: assert property (
    @(posedge clk) disable iff (rst)
    (cfg.buried || cfg.mode == MD_INREG) |-> !pin_oe);

endmodule

// File: rtl/mc_bank.sv
module mc_bank
  import mc_pkg::*;
#(
  parameter int N_CELL  = 4,
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CLK-1:0]      mclk,
  input  logic [N_CELL-1:0]       sum_in,
  input  logic [N_CELL-1:0]       pin_in,
  input  logic [N_CELL-1:0]       oe_in,
  input  logic [2*N_CELL-1:0]     cfg_mode,
  input  logic [N_CELL-1:0]       cfg_tff,
  input  logic [N_CELL-1:0]       cfg_inv,
  input  logic [SEL_W*N_CELL-1:0] cfg_csel,
  input  logic [N_CELL-1:0]       cfg_buried,
  output logic [N_CELL-1:0]       pin_out,
  output logic [N_CELL-1:0]       pin_oe,
  output logic [N_CELL-1:0]       fb_out
);

  logic [NUM_CLK-1:0]           lvl;
  logic [NUM_CLK-1:0]           rise;
  mc_cfg_t [N_CELL-1:0]         cfg_q;
  logic [N_CELL-1:0][SEL_W-1:0] csel_q;

  mc_clk_track #(.NUM_CLK(NUM_CLK)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .mclk      (mclk),
    .mclk_lvl  (lvl),
    .mclk_rise (rise)
  );

  mc_cfg_hold #(.N_CELL(N_CELL), .SEL_W(SEL_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .cfg_tff    (cfg_tff),
    .cfg_inv    (cfg_inv),
    .cfg_csel   (cfg_csel),
    .cfg_buried (cfg_buried),
    .cfg_q      (cfg_q),
    .csel_q     (csel_q)
  );

  for (genvar i = 0; i < N_CELL; i++) begin : g_cell
    mc_cell #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .cfg      (cfg_q[i]),
      .csel     (csel_q[i]),
      .clk_lvl  (lvl),
      .clk_rise (rise),
      .sum      (sum_in[i]),
      .pin_in   (pin_in[i]),
      .oe_req   (oe_in[i]),
      .pin_out  (pin_out[i]),
      .pin_oe   (pin_oe[i]),
      .fb       (fb_out[i])
    );
  end

endmodule

// File: tb/mc_bank_test.sv
`timescale 1ns/1ps
module mc_bank_test;

  localparam int N  = 4;
  localparam int NC = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [NC-1:0] mclk;
  logic [N-1:0]  sum_in, pin_in, oe_in, cfg_tff, cfg_inv, cfg_buried;
  logic [2*N-1:0]  cfg_mode;
  logic [SW*N-1:0] cfg_csel;
  logic [N-1:0]  pin_out, pin_oe, fb_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model state
  logic [N-1:0]  ms;
  logic [NC-1:0] mprev;
  logic [1:0]    m_mode [N];
  logic          m_tff [N];
  logic          m_inv [N];
  logic          m_bur [N];
  logic [1:0]    m_csel [N];

  always #2 clk = ~clk;

  mc_bank #(.N_CELL(N), .NUM_CLK(NC)) uut (
    .clk(clk), .rst(rst), .mclk(mclk), .sum_in(sum_in), .pin_in(pin_in),
    .oe_in(oe_in), .cfg_mode(cfg_mode), .cfg_tff(cfg_tff), .cfg_inv(cfg_inv),
    .cfg_csel(cfg_csel), .cfg_buried(cfg_buried),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  function automatic string tag_of(int i);
    case (m_mode[i])
      2'b00:   return "R1 R10";
      2'b01:   return m_tff[i] ? "R4 R6 R2" : "R3 R6 R2";
      2'b10:   return "R5 R6 R2";
      default: return "R7 R6";
    endcase
  endfunction

  function automatic logic exp_pin(int i);
    return (m_mode[i] == 2'b00) ? (sum_in[i] ^ m_inv[i]) : (ms[i] ^ m_inv[i]);
  endfunction

  function automatic logic exp_fb(int i);
    if (m_mode[i] == 2'b00) return sum_in[i] ^ m_inv[i];
    if (m_mode[i] == 2'b11) return ms[i];
    return ms[i] ^ m_inv[i];
  endfunction

  function automatic logic exp_oe(int i);
    return oe_in[i] & ~m_bur[i] & (m_mode[i] != 2'b11);
  endfunction

  // Apply one posedge worth of model update using the currently driven inputs
  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        ms[i]     = 1'b0;
        m_mode[i] = cfg_mode[2*i +: 2];
        m_tff[i]  = cfg_tff[i];
        m_inv[i]  = cfg_inv[i];
        m_bur[i]  = cfg_buried[i];
        m_csel[i] = cfg_csel[SW*i +: SW];
      end else begin
        logic r, l;
        r = mclk[m_csel[i]] & ~mprev[m_csel[i]];
        l = mclk[m_csel[i]];
        case (m_mode[i])
          2'b01: if (r) ms[i] = m_tff[i] ? (ms[i] ^ sum_in[i]) : sum_in[i];
          2'b10: if (l) ms[i] = sum_in[i];
          2'b11: if (r) ms[i] = pin_in[i];
          default: ;
        endcase
      end
    end
    mprev = rst ? '1 : mclk;
  endtask

  task automatic check_bit(string tag, string what, int i, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cell %0d %s: actual %b expected %b", tag, i, what, act, exp);
    end
  endtask

  task automatic cycle(string force_tag);
    @(posedge clk);
    @(negedge clk);
    model_step();
    for (int i = 0; i < N; i++) begin
      string t;
      t = (force_tag != "") ? force_tag : tag_of(i);
      check_bit(t, "pin_out", i, pin_out[i], exp_pin(i));
      check_bit(t, "fb_out", i, fb_out[i], exp_fb(i));
      check_bit((force_tag != "") ? force_tag : "R8", "pin_oe", i, pin_oe[i], exp_oe(i));
    end
  endtask

  task automatic drive_data();
    sum_in = N'($urandom);
    pin_in = N'($urandom);
    oe_in  = N'($urandom);
    for (int k = 0; k < NC; k++)
      if ($urandom_range(0, 2) == 0) mclk[k] = ~mclk[k];
  endtask

  task automatic scramble_cfg();
    cfg_mode   = (2*N)'($urandom);
    cfg_tff    = N'($urandom);
    cfg_inv    = N'($urandom);
    cfg_buried = N'($urandom);
    cfg_csel   = (SW*N)'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    mclk = '0;
    rst  = 1'b1;
    scramble_cfg();
    drive_data();
    for (int run = 0; run < 8; run++) begin
      rst = 1'b1;
      for (int i = 0; i < N; i++) cfg_mode[2*i +: 2] = 2'((run + i) % 4);
      cfg_tff    = N'($urandom);
      cfg_inv    = (run == 0) ? '0 : N'($urandom);
      cfg_buried = N'($urandom);
      cfg_csel   = (SW*N)'($urandom);
      drive_data();
      cycle("R9");
      drive_data();
      cycle("R9");
      // Corner: every macro clock high over reset release
      mclk = '1;
      cycle("R9");
      rst = 1'b0;
      scramble_cfg();
      cycle("R9 R10");
      drive_data();
      for (int c = 0; c < 250; c++) begin
        cycle("");
        drive_data();
        if (c % 37 == 0) scramble_cfg();
      end
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule